// File: doc/BRIEF.md
# Asynchronous 8-N-1 Serial Receiver with Line-Idle and Break Flags

This block recovers bytes from an asynchronous serial line with one start bit, eight data bits, no parity and one stop bit. The line rests high and a frame opens with a low start bit. The receiver samples the line with the system clock. A programmable divisor sets an oversampling tick, and every bit lasts sixteen ticks. Each recovered byte appears on `data_o` together with a one-cycle `valid_o` strobe. A stop bit that samples low also raises `frame_err_o`, so upper layers can throw away a message that has lost framing.

Each falling edge of a start bit restarts the bit timing. The receiver arms itself for the next start bit as soon as the stop bit has been sampled at its centre. It does not wait out the rest of the stop bit. As a result, a transmitter running a little fast, or one that sends shortened stop bits, can stream characters with no gaps and the receiver does not slip.

Two line-watch flags count whole bit times. `idle_o` reports a line that has stayed high for more than eleven bit times. `break_o` reports a line that has stayed low for eleven bit times.

Top module: `serial_rx8n1`

## Requirements
- R1: Frames are one low start bit, eight data bits sent least significant bit first, and one stop bit. For each frame `data_o` takes the byte and `valid_o` is high for exactly one clock. `data_o` holds its value until the next strobe.
- R2: An oversampling tick occurs once every `div_i` clocks (`div_i` of 0 or 1 gives a tick every clock). One bit time is 16 ticks.
- R3: A falling edge on the line starts a candidate frame. If the line is no longer low at the eighth tick, the candidate is discarded as a glitch and no byte is produced.
- R4: Each data bit and the stop bit are decided by a majority vote over three consecutive tick samples near the bit centre. A line disturbance shorter than one tick therefore does not alter the byte.
- R5: Start-bit detection is re-armed once the stop bit has been sampled at its centre. A stop bit cut down to about two thirds of a bit is accepted, and so is a back-to-back stream from a transmitter running about 3 % fast.
- R6: When the stop bit votes low and the data byte is non-zero, the byte is delivered with `frame_err_o` high in the same cycle as `valid_o`. After such a frame a new frame starts only on a fresh falling edge.
- R7: `break_o` rises once the line has been low for 11 bit times (176 ticks). It stays high until the line returns high. A break produces no byte, and reception resumes at the next start bit.
- R8: `idle_o` rises once the line has been high for more than 11 bit times (177 ticks). It drops as soon as the line is seen low. `idle_o` and `break_o` are never high together.
- R9: While `rst_n` is low, every output is 0, and the line is taken as high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_i | input | 12 | Clocks per oversampling tick |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| data_o | output | 8 | Last received byte |
| valid_o | output | 1 | One-cycle strobe for a new byte |
| frame_err_o | output | 1 | Stop bit sampled low, valid with `valid_o` |
| idle_o | output | 1 | Line high for more than 11 bit times |
| break_o | output | 1 | Line low for at least 11 bit times |

## Verification
The assertions assume three things:
- `div_i` stays constant while traffic is present.
- The line is never held low for a whole frame and then released at the very moment a byte would be delivered.
- No two strobes can fall within one bit time of each other.

The stimulus programs one divisor right after reset and leaves it unchanged. Every level change on the line lasts at least three clocks, except for the spike aimed at a data-bit centre. Bytes are spaced by at least a stop bit, and breaks are released only well after `break_o` has risen.

// File: rtl/serial_rx_pkg.sv
// Shared definitions for the serial receiver.
// Assumes 8-N-1 framing; the data width is fixed by the frame format.
package serial_rx_pkg;

    localparam int unsigned FRAME_BITS = 8;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_HOLD
    } rx_state_e;

endpackage

// File: rtl/rx_sync.sv
// Two-flop synchroniser for the asynchronous line with a falling-edge pulse.
// Assumes the line idles high; the flops reset to 1 so reset produces no edge.
module rx_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_i,
    output logic rx_s,
    output logic fall_o
);
    logic meta_q;
    logic sync_q;
    logic prev_q;

    // Move the line into the clock domain and keep one older copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            meta_q <= rx_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rx_s   = sync_q;
    assign fall_o = prev_q & ~sync_q;
endmodule

// File: rtl/rx_tick.sv
// Free-running oversampling tick generator: one pulse every div_i clocks.
// Assumes div_i is static while frames are in flight; 0 and 1 tick every clock.
module rx_tick #(
    parameter int unsigned DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_q;
    logic             wrap;

    // Wrap when the count reaches the divisor minus one.
    assign wrap = (div_i <= DIV_W'(1)) || (cnt_q >= div_i - DIV_W'(1));

    // Count clocks and emit the registered tick pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_o <= 1'b0;
        end else begin
            cnt_q  <= wrap ? '0 : cnt_q + DIV_W'(1);
            tick_o <= wrap;
        end
    end
endmodule

// File: rtl/rx_linewatch.sv
// Counts consecutive ticks of constant line level to flag idle and break.
// Assumes rx_s is already synchronised; any change of level restarts a count.
module rx_linewatch #(
    parameter int unsigned OS         = 16,
    parameter int unsigned IDLE_BITS  = 11,
    parameter int unsigned BRK_BITS   = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic rx_s,
    output logic idle_o,
    output logic break_o
);
    localparam int unsigned IDLE_T = OS * IDLE_BITS + 1;
    localparam int unsigned BRK_T  = OS * BRK_BITS;
    localparam int unsigned MAX_T  = (IDLE_T > BRK_T) ? IDLE_T : BRK_T;
    localparam int unsigned CW     = $clog2(MAX_T + 1);
    localparam logic [CW-1:0] IDLE_LIM = CW'(IDLE_T);
    localparam logic [CW-1:0] BRK_LIM  = CW'(BRK_T);

    logic [CW-1:0] hi_cnt;
    logic [CW-1:0] lo_cnt;

    // High-level run length; idle once more than IDLE_BITS bit times.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= '0;
            idle_o <= 1'b0;
        end else if (!rx_s) begin
            hi_cnt <= '0;
            idle_o <= 1'b0;
        end else if (tick_i && hi_cnt != IDLE_LIM) begin
            hi_cnt <= hi_cnt + CW'(1);
            if (hi_cnt == IDLE_LIM - CW'(1)) idle_o <= 1'b1;
        end
    end

    // Low-level run length; break once BRK_BITS bit times have passed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_cnt  <= '0;
            break_o <= 1'b0;
        end else if (rx_s) begin
            lo_cnt  <= '0;
            break_o <= 1'b0;
        end else if (tick_i && lo_cnt != BRK_LIM) begin
            lo_cnt <= lo_cnt + CW'(1);
            if (lo_cnt == BRK_LIM - CW'(1)) break_o <= 1'b1;
        end
    end
endmodule

// File: rtl/rx_framer.sv
// Frame state machine: start confirmation, voted data bits, stop check.
// Assumes OS ticks per bit and a falling-edge pulse from the synchroniser.
// Re-arms at the stop-bit centre; an all-zero frame with a low stop bit
// waits for the line to rise and is dropped if a break was flagged.
module rx_framer
    import serial_rx_pkg::*;
#(
    parameter int unsigned OS = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick_i,
    input  logic                  rx_s,
    input  logic                  fall_i,
    input  logic                  break_i,
    output logic [FRAME_BITS-1:0] data_o,
    output logic                  valid_o,
    output logic                  frame_err_o
);
    localparam int unsigned OSW  = $clog2(OS);
    localparam int unsigned BW   = $clog2(FRAME_BITS);
    localparam logic [OSW-1:0] HALF_M1 = OSW'(OS / 2 - 1);
    localparam logic [OSW-1:0] FULL_M1 = OSW'(OS - 1);
    localparam logic [BW-1:0]  LAST_B  = BW'(FRAME_BITS - 1);

    rx_state_e             state_q;
    logic [OSW-1:0]        os_q;
    logic [BW-1:0]         bit_q;
    logic [FRAME_BITS-1:0] shift_q;
    logic [1:0]            hist_q;
    logic                  vote;

    // Majority of the two previous tick samples and the current level.
    assign vote = (hist_q[1] & hist_q[0]) | (hist_q[1] & rx_s) | (hist_q[0] & rx_s);

    // Record the line level at every tick for the vote.
    always_ff @(posedge clk) begin
        if (!rst_n)      hist_q <= 2'b11;
        else if (tick_i) hist_q <= {hist_q[0], rx_s};
    end

    // Walk a frame and deliver bytes with their framing status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= RX_IDLE;
            os_q        <= '0;
            bit_q       <= '0;
            shift_q     <= '0;
            data_o      <= '0;
            valid_o     <= 1'b0;
            frame_err_o <= 1'b0;
        end else begin
            valid_o     <= 1'b0;
            frame_err_o <= 1'b0;
            case (state_q)
                RX_IDLE: begin
                    if (fall_i) begin
                        state_q <= RX_START;
                        os_q    <= '0;
                    end
                end
                RX_START: begin
                    if (tick_i) begin
                        if (os_q == HALF_M1) begin
                            os_q    <= '0;
                            bit_q   <= '0;
                            state_q <= rx_s ? RX_IDLE : RX_DATA;
                        end else begin
                            os_q <= os_q + OSW'(1);
                        end
                    end
                end
                RX_DATA: begin
                    if (tick_i) begin
                        if (os_q == FULL_M1) begin
                            os_q    <= '0;
                            shift_q <= {vote, shift_q[FRAME_BITS-1:1]};
                            if (bit_q == LAST_B) state_q <= RX_STOP;
                            else                 bit_q   <= bit_q + BW'(1);
                        end else begin
                            os_q <= os_q + OSW'(1);
                        end
                    end
                end
                RX_STOP: begin
                    if (tick_i) begin
                        if (os_q == FULL_M1) begin
                            os_q <= '0;
                            if (vote) begin
                                data_o  <= shift_q;
                                valid_o <= 1'b1;
                                state_q <= RX_IDLE;
                            end else if (shift_q != '0) begin
                                data_o      <= shift_q;
                                valid_o     <= 1'b1;
                                frame_err_o <= 1'b1;
                                state_q     <= RX_IDLE;
                            end else begin
                                state_q <= RX_HOLD;
                            end
                        end else begin
                            os_q <= os_q + OSW'(1);
                        end
                    end
                end
                RX_HOLD: begin
                    if (rx_s) begin
                        if (!break_i) begin
                            data_o      <= '0;
                            valid_o     <= 1'b1;
                            frame_err_o <= 1'b1;
                        end
                        state_q <= RX_IDLE;
                    end
                end
                default: state_q <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/serial_rx8n1.sv
// Top of the 8-N-1 serial receiver: synchroniser, tick generator,
// frame state machine and line watcher.
// Assumes an idle-high line and a divisor set before traffic starts.
module serial_rx8n1 #(
    parameter int unsigned DIV_W     = 12,
    parameter int unsigned OS        = 16,
    parameter int unsigned IDLE_BITS = 11,
    parameter int unsigned BRK_BITS  = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    input  logic             rx_i,
    output logic [7:0]       data_o,
    output logic             valid_o,
    output logic             frame_err_o,
    output logic             idle_o,
    output logic             break_o
);
    logic rx_s;
    logic fall;
    logic tick;

    rx_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .rx_i   (rx_i),
        .rx_s   (rx_s),
        .fall_o (fall)
    );

    rx_tick #(.DIV_W(DIV_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .div_i  (div_i),
        .tick_o (tick)
    );

    rx_linewatch #(.OS(OS), .IDLE_BITS(IDLE_BITS), .BRK_BITS(BRK_BITS)) u_watch (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick),
        .rx_s    (rx_s),
        .idle_o  (idle_o),
        .break_o (break_o)
    );

    rx_framer #(.OS(OS)) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .rx_s        (rx_s),
        .fall_i      (fall),
        .break_i     (break_o),
        .data_o      (data_o),
        .valid_o     (valid_o),
        .frame_err_o (frame_err_o)
    );
endmodule

// File: rtl/serial_rx8n1_chk.sv
// Property checker for the serial receiver, bound to the top module.
// Assumes the synchronised line level is visible as rx_s in the top.
module serial_rx8n1_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_s,
    input logic valid_o,
    input logic frame_err_o,
    input logic idle_o,
    input logic break_o
);
    // R1: the byte strobe lasts a single clock.
    assert_valid_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R6: a framing error is only reported alongside a byte.
    assert_fe_with_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err_o |-> valid_o);

    // R7: no byte is delivered while a break is flagged.
    assert_break_no_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
        break_o |-> !valid_o);

    // R7: a break is released once the line is back high.
    assert_break_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (break_o && rx_s) |=> !break_o);

    // R7: a break only starts while the line is low.
    assert_break_rise_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(break_o) |-> !$past(rx_s));

    // R8: idle drops when the line is seen low.
    assert_idle_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_o && !rx_s) |=> !idle_o);

    // R8: idle and break are mutually exclusive.
    assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(idle_o && break_o));
endmodule

bind serial_rx8n1 serial_rx8n1_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_s        (rx_s),
    .valid_o     (valid_o),
    .frame_err_o (frame_err_o),
    .idle_o      (idle_o),
    .break_o     (break_o)
);

// File: tb/serial_rx8n1_test.sv
`timescale 1ns/1ps
module serial_rx8n1_test;
    localparam int BIT = 64;              // clocks per bit with div 4
    localparam int NV  = 8;
    // {byte, transmit bit period in clocks}
    localparam logic [15:0] VEC [0:NV-1] = '{
        {8'h55, 8'd64}, {8'hAA, 8'd64}, {8'h00, 8'd64}, {8'hFF, 8'd64},
        {8'h01, 8'd63}, {8'h80, 8'd65}, {8'h3C, 8'd62}, {8'hE7, 8'd66}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] div_i = 12'd4;
    logic        rx_i = 1'b1;
    logic [7:0]  data_o;
    logic        valid_o, frame_err_o, idle_o, break_o;

    int n_chk = 0;
    int n_fail = 0;
    int rx_n = 0;
    logic [7:0] rx_d [0:255];
    logic       rx_f [0:255];

    always #5 clk = ~clk;

    serial_rx8n1 uut (
        .clk(clk), .rst_n(rst_n), .div_i(div_i), .rx_i(rx_i),
        .data_o(data_o), .valid_o(valid_o), .frame_err_o(frame_err_o),
        .idle_o(idle_o), .break_o(break_o)
    );

    // Capture every delivered byte away from the active edge.
    always @(negedge clk) begin
        if (rst_n && valid_o && rx_n < 256) begin
            rx_d[rx_n] = data_o;
            rx_f[rx_n] = frame_err_o;
            rx_n++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold(input logic v, input int n);
        rx_i = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b, input int per, input int stop_len);
        hold(1'b0, per);
        for (int i = 0; i < 8; i++) hold(b[i], per);
        hold(1'b1, stop_len);
    endtask

    task automatic expect_byte(input string req, input int base, input logic [7:0] b, input logic fe);
        chk({req, " count"}, rx_n, base + 1);
        if (rx_n > base) begin
            chk({req, " data"}, rx_d[base], b);
            chk({req, " frame_err"}, rx_f[base], fe);
        end
    endtask

    initial begin
        int base;
        repeat (10) @(negedge clk);
        // R9: outputs cleared in reset.
        chk("R9 valid", valid_o, 0);
        chk("R9 frame_err", frame_err_o, 0);
        chk("R9 break", break_o, 0);
        chk("R9 idle", idle_o, 0);
        chk("R9 data", data_o, 0);
        rst_n = 1'b1;
        hold(1'b1, 2 * BIT);

        // R1 R2: table of bytes at nominal and slightly off rates.
        for (int k = 0; k < NV; k++) begin
            base = rx_n;
            send(VEC[k][15:8], int'(VEC[k][7:0]), int'(VEC[k][7:0]));
            hold(1'b1, 2 * BIT);
            expect_byte("R1 table", base, VEC[k][15:8], 1'b0);
        end

        // R3: short low pulse is a glitch, then a normal byte follows.
        base = rx_n;
        hold(1'b0, 12);
        hold(1'b1, 3 * BIT);
        chk("R3 glitch no byte", rx_n, base);
        send(8'h96, BIT, BIT);
        hold(1'b1, BIT);
        expect_byte("R3 after glitch", base, 8'h96, 1'b0);

        // R4: a 3-clock spike at the centre of data bit 3 is voted out.
        base = rx_n;
        hold(1'b0, BIT);
        for (int i = 0; i < 8; i++) begin
            if (i == 3) begin
                hold(1'b0, 30); hold(1'b1, 3); hold(1'b0, 31);
            end else begin
                hold(8'hA5 >> i, BIT);
            end
        end
        hold(1'b1, 2 * BIT);
        expect_byte("R4 spike", base, 8'hA5, 1'b0);

        // R5: fast transmitter, ten characters back to back.
        base = rx_n;
        for (int k = 0; k < 10; k++) send(8'hA5 ^ (8'h11 * k), 62, 62);
        hold(1'b1, 2 * BIT);
        chk("R5 fast count", rx_n, base + 10);
        for (int k = 0; k < 10; k++) chk("R5 fast data", rx_d[base + k], 8'hA5 ^ (8'h11 * k));

        // R5: shortened stop bits, six characters back to back.
        base = rx_n;
        for (int k = 0; k < 6; k++) send(8'h3E + 8'(k * 7), BIT, 44);
        hold(1'b1, 2 * BIT);
        chk("R5 short stop count", rx_n, base + 6);
        for (int k = 0; k < 6; k++) chk("R5 short stop data", rx_d[base + k], 8'h3E + 8'(k * 7));

        // R6: low stop bit with non-zero data.
        base = rx_n;
        hold(1'b0, BIT);
        for (int i = 0; i < 8; i++) hold(8'h5A >> i, BIT);
        hold(1'b0, 40);
        hold(1'b1, 3 * BIT);
        expect_byte("R6 framing", base, 8'h5A, 1'b1);
        chk("R6 no extra frame", rx_n, base + 1);

        // R7: break of 15 bit times.
        base = rx_n;
        hold(1'b0, 10 * BIT);
        chk("R7 not yet break", break_o, 0);
        hold(1'b0, 3 * BIT);
        chk("R7 break set", break_o, 1);
        chk("R8 idle off in break", idle_o, 0);
        hold(1'b0, 2 * BIT);
        hold(1'b1, 6);
        chk("R7 break cleared", break_o, 0);
        hold(1'b1, 2 * BIT);
        chk("R7 no byte for break", rx_n, base);
        send(8'hC3, BIT, BIT);
        hold(1'b1, BIT);
        expect_byte("R7 resume", base, 8'hC3, 1'b0);

        // R8: idle flag timing after a byte ending in a low bit.
        hold(1'b1, 2 * BIT);
        base = rx_n;
        send(8'h3C, BIT, BIT);
        hold(1'b1, 8 * BIT);
        chk("R8 idle not yet", idle_o, 0);
        hold(1'b1, 4 * BIT);
        chk("R8 idle set", idle_o, 1);
        hold(1'b0, 8);
        chk("R8 idle cleared", idle_o, 0);
        hold(1'b0, BIT - 8);
        for (int i = 0; i < 8; i++) hold(8'h81 >> i, BIT);
        hold(1'b1, 2 * BIT);
        chk("R8 count", rx_n, base + 2);
        chk("R8 data", rx_d[base + 1], 8'h81);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1500000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule